// File: doc/BRIEF.md
# LPDDR Mode-Register Initialisation Sequencer

This block drives the mode-register programming phase of an LPDDR device after power-up. A single start pulse launches a fixed series of six mode-register commands to rank 0. When the dual-rank input is high at start, the same six commands then go to rank 1. Each command value comes from an input that the surrounding controller holds steady. The block places the rank number above the payload in the command word and raises a request line for a set hold time.

Before the first command, the block waits out the device initialisation interval. Every command then follows one pattern: the request rises, stays high for the command's hold time, and falls for a fixed gap before the next command. The reset command needs a long hold. The other five commands use a short hold. All intervals are cycle-count parameters. A busy flag covers the whole run and a one-cycle done pulse marks its end. A separate output forces the second rank's clock enable off while the block is configured for one rank.

Top module: `mrs_init_seq`

## Requirements
- R1: After reset, `busy_o`, `cmd_req_o`, `done_o` and `cke1_off_o` are all low.
- R2: A start accepted while idle raises `busy_o` in the next cycle. The request then stays low for exactly `INIT_CYC` cycles before the first command.
- R3: For each rank, the six commands take their payloads in this order: `mr_reset_i`, `mr_zq_i`, `mr_io_i`, `mr_dev1_i`, `mr_dev2_i`, `mr_odt_i`.
- R4: `cmd_req_o` stays high for `LONG_HOLD_CYC` cycles for the first command of a rank and for `SHORT_HOLD_CYC` cycles for every other command. After each command it stays low for `GAP_CYC` cycles.
- R5: While the request is high, `cmd_word_o[27:0]` carries the payload, bit 28 carries the rank (0 or 1), and bits 31:29 are zero.
- R6: The rank-1 series starts right after the last gap of rank 0, only if `dual_rank_i` was high at the accepted start. Otherwise rank 1 receives no command.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last gap. `busy_o` falls in that same cycle.
- R8: While busy, a start pulse and any change on `dual_rank_i` have no effect on the running sequence.
- R9: At each accepted start, `cke1_off_o` takes the inverse of `dual_rank_i` and holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dual_rank_i | input | 1 | Rank-1 present, sampled at start |
| mr_reset_i | input | PAYLOAD_W | Payload of command 1 (device reset) |
| mr_zq_i | input | PAYLOAD_W | Payload of command 2 (impedance calibration start) |
| mr_io_i | input | PAYLOAD_W | Payload of command 3 (I/O drive) |
| mr_dev1_i | input | PAYLOAD_W | Payload of command 4 (device setup 1) |
| mr_dev2_i | input | PAYLOAD_W | Payload of command 5 (device setup 2) |
| mr_odt_i | input | PAYLOAD_W | Payload of command 6 (termination) |
| cmd_word_o | output | CMD_W | Command word: payload, rank bit above it |
| cmd_req_o | output | 1 | Command request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cke1_off_o | output | 1 | Forces the rank-1 clock enable off |

## Verification
All outputs come from registers updated at the clock edge that samples the stimulus. The cycle of each result therefore follows from the hold times:
- `busy_o` and `cke1_off_o` follow one cycle after the start edge.
- The first request comes `INIT_CYC` cycles later.
- Each later request edge comes one hold or gap length after the previous one.
- `done_o` comes exactly one cycle after the end of the last gap.

The bench counts cycles from the start edge and samples at the falling edge of every cycle. At each sample it compares every output with a value worked out arithmetically from that count and the four interval parameters. Start pulses and dual-rank flips are injected in the middle of a run, and the same cycle-by-cycle comparison shows that they change nothing.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_REQ  = 2'd2,
      ST_GAP  = 2'd3
   } seq_state_t;

   localparam int unsigned NUM_CMDS = 6;
   localparam int unsigned IDX_W    = $clog2(NUM_CMDS);
   localparam int unsigned LAST_IDX = NUM_CMDS - 1;

   typedef logic [IDX_W-1:0] cmd_idx_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mrs_dly_timer.sv
module mrs_dly_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

   // R4: once at zero, the timer stays there until reloaded
   a_r4_timer_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/mrs_cmd_sel.sv
module mrs_cmd_sel
   import mrs_seq_pkg::*;
#(
   parameter int unsigned PAYLOAD_W = 28,
   parameter int unsigned CMD_W     = 32
) (
   input  logic [NUM_CMDS-1:0][PAYLOAD_W-1:0] tab_i,
   input  cmd_idx_t                           idx_i,
   input  logic                               rank_i,
   output logic [CMD_W-1:0]                   word_o
);

   localparam int unsigned PAD_W = CMD_W - PAYLOAD_W - 1;

   logic [NUM_CMDS-1:0]                hit;
   logic [NUM_CMDS-1:0][PAYLOAD_W-1:0] part;
   logic [PAYLOAD_W-1:0]               payload;

   for (genvar g = 0; g < NUM_CMDS; g++) begin : g_slot
      assign hit[g]  = (idx_i == cmd_idx_t'(g));
      assign part[g] = hit[g] ? tab_i[g] : '0;
   end

   always_comb begin
      payload = '0;
      for (int i = 0; i < NUM_CMDS; i++) begin
         payload = payload | part[i];
      end
   end

   if (PAD_W == 0) begin : g_tight
      assign word_o = {rank_i, payload};
   end else begin : g_padded
      assign word_o = {{PAD_W{1'b0}}, rank_i, payload};
   end

endmodule

// File: rtl/mrs_seq_ctrl.sv
module mrs_seq_ctrl
   import mrs_seq_pkg::*;
#(
   parameter int unsigned INIT_CYC       = 50000,
   parameter int unsigned LONG_HOLD_CYC  = 2500,
   parameter int unsigned SHORT_HOLD_CYC = 250,
   parameter int unsigned GAP_CYC        = 4,
   parameter int unsigned CNT_W          = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             dual_i,
   input  logic             expired_i,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output cmd_idx_t         idx_o,
   output logic             rank_o,
   output logic             req_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             cke1_off_o
);

   localparam logic [CNT_W-1:0] INIT_V  = CNT_W'(INIT_CYC - 1);
   localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_V   = CNT_W'(GAP_CYC - 1);
   localparam cmd_idx_t         LAST    = cmd_idx_t'(LAST_IDX);

   seq_state_t state_q;
   cmd_idx_t   idx_q;
   logic       rank_q;
   logic       dual_q;
   logic       cke_off_q;
   logic       done_q;

   logic       rank_end;
   logic       more_ranks;

   assign rank_end   = (idx_q == LAST);
   assign more_ranks = !rank_q && dual_q;

   always_comb begin
      load_o     = 1'b0;
      load_val_o = '0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            load_o     = 1'b1;
            load_val_o = INIT_V;
         end
         ST_WAIT: if (expired_i) begin
            load_o     = 1'b1;
            load_val_o = LONG_V;
         end
         ST_REQ: if (expired_i) begin
            load_o     = 1'b1;
            load_val_o = GAP_V;
         end
         ST_GAP: if (expired_i && (!rank_end || more_ranks)) begin
            load_o     = 1'b1;
            load_val_o = rank_end ? LONG_V : SHORT_V;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         rank_q    <= 1'b0;
         dual_q    <= 1'b0;
         cke_off_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q   <= ST_WAIT;
               idx_q     <= '0;
               rank_q    <= 1'b0;
               dual_q    <= dual_i;
               cke_off_q <= !dual_i;
            end
            ST_WAIT: if (expired_i) state_q <= ST_REQ;
            ST_REQ:  if (expired_i) state_q <= ST_GAP;
            ST_GAP: if (expired_i) begin
               if (!rank_end) begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_REQ;
               end else if (more_ranks) begin
                  idx_q   <= '0;
                  rank_q  <= 1'b1;
                  state_q <= ST_REQ;
               end else begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign idx_o      = idx_q;
   assign rank_o     = rank_q;
   assign req_o      = (state_q == ST_REQ);
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign cke1_off_o = cke_off_q;

   // Independent length counter for the request window.
   logic [CNT_W-1:0] req_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                req_run_q <= '0;
      else if (state_q == ST_REQ) req_run_q <= req_run_q + 1'b1;
      else                       req_run_q <= '0;
   end

   // R4: request window length matches the command's hold class
   a_r4_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REQ && expired_i) |-> (req_run_q == ((idx_q == '0) ? LONG_V : SHORT_V)));

   // R3: command index never leaves the table
   a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);

   // R6: rank 1 is only reached when dual rank was latched
   a_r6_rank1_dual: assert property (@(posedge clk) disable iff (!rst_n)
      rank_q |-> dual_q);

endmodule

// File: rtl/mrs_init_seq.sv
module mrs_init_seq
   import mrs_seq_pkg::*;
#(
   parameter int unsigned PAYLOAD_W      = 28,
   parameter int unsigned CMD_W          = 32,
   parameter int unsigned INIT_CYC       = 50000,
   parameter int unsigned LONG_HOLD_CYC  = 2500,
   parameter int unsigned SHORT_HOLD_CYC = 250,
   parameter int unsigned GAP_CYC        = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 dual_rank_i,
   input  logic [PAYLOAD_W-1:0] mr_reset_i,
   input  logic [PAYLOAD_W-1:0] mr_zq_i,
   input  logic [PAYLOAD_W-1:0] mr_io_i,
   input  logic [PAYLOAD_W-1:0] mr_dev1_i,
   input  logic [PAYLOAD_W-1:0] mr_dev2_i,
   input  logic [PAYLOAD_W-1:0] mr_odt_i,
   output logic [CMD_W-1:0]     cmd_word_o,
   output logic                 cmd_req_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 cke1_off_o
);

   localparam int unsigned MAX_CYC = max2(max2(INIT_CYC, LONG_HOLD_CYC),
                                          max2(SHORT_HOLD_CYC, GAP_CYC));
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   if (CMD_W < PAYLOAD_W + 1) begin : g_chk_width
      $error("CMD_W must leave room for the rank bit above the payload");
   end
   if (INIT_CYC < 1 || LONG_HOLD_CYC < 1 || SHORT_HOLD_CYC < 1 || GAP_CYC < 1) begin : g_chk_cyc
      $error("all interval parameters must be at least one cycle");
   end

   logic [NUM_CMDS-1:0][PAYLOAD_W-1:0] tab;
   assign tab = {mr_odt_i, mr_dev2_i, mr_dev1_i, mr_io_i, mr_zq_i, mr_reset_i};

   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             expired;
   cmd_idx_t         idx;
   logic             rank;

   mrs_dly_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .expired_o  (expired)
   );

   mrs_seq_ctrl #(
      .INIT_CYC       (INIT_CYC),
      .LONG_HOLD_CYC  (LONG_HOLD_CYC),
      .SHORT_HOLD_CYC (SHORT_HOLD_CYC),
      .GAP_CYC        (GAP_CYC),
      .CNT_W          (CNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .dual_i     (dual_rank_i),
      .expired_i  (expired),
      .load_o     (load),
      .load_val_o (load_val),
      .idx_o      (idx),
      .rank_o     (rank),
      .req_o      (cmd_req_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .cke1_off_o (cke1_off_o)
   );

   mrs_cmd_sel #(.PAYLOAD_W(PAYLOAD_W), .CMD_W(CMD_W)) u_sel (
      .tab_i  (tab),
      .idx_i  (idx),
      .rank_i (rank),
      .word_o (cmd_word_o)
   );

   // R4: no request outside a busy run
   a_r4_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req_o |-> busy_o);

   // R7: done is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: done coincides with busy falling
   a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R9: clock-enable override cannot change during a run
   a_r9_cke_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(cke1_off_o));

endmodule

// File: tb/sim_mrs_init_seq.sv
`timescale 1ns/1ps
module sim_mrs_init_seq;

   localparam int INIT  = 7;
   localparam int LONG  = 5;
   localparam int SHORT = 2;
   localparam int GAP   = 3;
   localparam int RLEN  = LONG + 5*SHORT + 6*GAP;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        dual_rank_i = 1'b0;
   logic [27:0] pay [6];
   logic [31:0] cmd_word_o;
   logic        cmd_req_o, busy_o, done_o, cke1_off_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   mrs_init_seq #(
      .PAYLOAD_W(28), .CMD_W(32), .INIT_CYC(INIT),
      .LONG_HOLD_CYC(LONG), .SHORT_HOLD_CYC(SHORT), .GAP_CYC(GAP)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dual_rank_i(dual_rank_i),
      .mr_reset_i(pay[0]), .mr_zq_i(pay[1]), .mr_io_i(pay[2]),
      .mr_dev1_i(pay[3]), .mr_dev2_i(pay[4]), .mr_odt_i(pay[5]),
      .cmd_word_o(cmd_word_o), .cmd_req_o(cmd_req_o), .busy_o(busy_o),
      .done_o(done_o), .cke1_off_o(cke1_off_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic void expect_at(input int t, input bit dual,
                                     output bit busy, output bit req, output bit done,
                                     output int idx, output int rank);
      int total;
      int u;
      int v;
      int w;
      total = INIT + RLEN * (dual ? 2 : 1);
      busy  = (t >= 1) && (t <= total);
      done  = (t == total + 1);
      req   = 1'b0;
      idx   = 0;
      rank  = 0;
      if (t > INIT && t <= total) begin
         u    = t - INIT - 1;
         rank = u / RLEN;
         v    = u % RLEN;
         if (v < LONG + GAP) begin
            idx = 0;
            req = (v < LONG);
         end else begin
            w   = v - LONG - GAP;
            idx = 1 + w / (SHORT + GAP);
            req = (w % (SHORT + GAP)) < SHORT;
         end
      end
   endfunction

   // Runs one sequence, optionally poking start and dual_rank mid-run (R8).
   task automatic run_seq(input bit dual, input int seed, input bit poke);
      int  total;
      bit  eb, er, ed;
      int  ei, ek;
      string pre;
      for (int i = 0; i < 6; i++)
         pay[i] = 28'((seed * 32'h01234567) ^ (i * 32'h00111111) ^ 32'h0ABCDEF ^ (i << 20));
      total = INIT + RLEN * (dual ? 2 : 1);
      pre = poke ? "R8 " : "";
      @(negedge clk);
      start_i = 1'b1;
      dual_rank_i = dual;
      @(negedge clk);
      start_i = 1'b0;
      for (int t = 1; t <= total + 2; t++) begin
         expect_at(t, dual, eb, er, ed, ei, ek);
         chk({pre, "R2 busy"}, 32'(busy_o), 32'(eb));
         chk({pre, (t <= INIT + LONG) ? "R2 req" : "R4 req"}, 32'(cmd_req_o), 32'(er));
         chk({pre, "R7 done"}, 32'(done_o), 32'(ed));
         chk({pre, "R9 cke1_off"}, 32'(cke1_off_o), 32'(!dual));
         if (er) begin
            chk({pre, "R3 payload"}, 32'(cmd_word_o[27:0]), 32'(pay[ei]));
            chk({pre, (ek == 1) ? "R6 rank" : "R5 rank"}, 32'(cmd_word_o[31:28]), 32'(ek));
         end
         if (poke && t == INIT + 3) begin
            start_i = 1'b1;
            dual_rank_i = !dual;
         end
         if (poke && t == INIT + 4) begin
            start_i = 1'b0;
         end
         if (poke && t == INIT + RLEN - 2) begin
            start_i = 1'b1;
         end
         if (poke && t == INIT + RLEN - 1) begin
            start_i = 1'b0;
            dual_rank_i = dual;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      for (int i = 0; i < 6; i++) pay[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1 busy", 32'(busy_o), 32'd0);
      chk("R1 req", 32'(cmd_req_o), 32'd0);
      chk("R1 done", 32'(done_o), 32'd0);
      chk("R1 cke1_off", 32'(cke1_off_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", 32'(busy_o), 32'd0);

      run_seq(1'b0, 1, 1'b0);
      run_seq(1'b1, 2, 1'b0);
      run_seq(1'b0, 3, 1'b1);
      run_seq(1'b1, 4, 1'b1);
      run_seq(1'b1, 5, 1'b0);
      run_seq(1'b0, 6, 1'b0);

      repeat (4) @(negedge clk);
      chk("R9 cke1_off held", 32'(cke1_off_o), 32'd1);
      chk("R7 idle busy", 32'(busy_o), 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule